// File: doc/BRIEF.md
# BCD Decimal Adjust Unit

This block repairs an 8-bit accumulator after a binary add or subtract of two packed BCD operands, so that the byte again holds two valid decimal digits. It is purely combinational. It reads the accumulator together with the carry, half-carry and subtract flags left by the preceding operation. From these it forms a correction byte, adds that byte to the accumulator modulo 256, and returns the repaired byte with a fresh flag set.

The correction depends on which digits need repair and on the direction of the previous operation. One flag decides the low digit: it is set when the low nibble is above nine or the half-carry input is set. The other flag decides the high digit: it is set when the whole byte is above 0x99 or the carry input is set. In subtract direction the correction bytes are the two's complements of the add-direction bytes. The status outputs (sign, zero, parity, and copies of result bits 3 and 5) all describe the repaired byte. Half-carry follows its own rule, evaluated on the byte before correction.

Top module: `bcd_adjust`

## Requirements
- R1: Low-digit repair is selected when acc_in[3:0] > 9 or half_in = 1; otherwise the low-digit part of the correction is zero.
- R2: High-digit repair is selected when acc_in > 0x99 or carry_in = 1. When it is selected, carry_out = 1.
- R3: With sub_in = 0, acc_out = acc_in + 0x06 (low repair only), + 0x60 (high repair only) or + 0x66 (both), modulo 256.
- R4: With sub_in = 1, acc_out = acc_in + 0xFA (low repair only), + 0xA0 (high repair only) or + 0x9A (both), modulo 256. With neither repair selected, acc_out = acc_in in either direction.
- R5: half_out = (acc_in[3:0] >= 0xA) when sub_in = 0. half_out = (acc_in[3:0] < 6) when sub_in = 1 and half_in = 1. half_out = 0 when sub_in = 1 and half_in = 0.
- R6: sign_out = acc_out[7]. zero_out = 1 exactly when acc_out = 0x00. parity_out = 1 exactly when acc_out has an even number of ones.
- R7: bit3_copy = acc_out[3] and bit5_copy = acc_out[5].
- R8: sub_out equals sub_in. carry_out equals carry_in unless high-digit repair forces it to 1.
- R9: A sum above 0xFF wraps modulo 256. For example, acc_in = 0x9A in add direction yields acc_out = 0x00 with carry_out = 1, zero_out = 1 and half_out = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| acc_in | input | 8 | Accumulator before adjustment |
| half_in | input | 1 | Half-carry flag from the previous operation |
| carry_in | input | 1 | Carry flag from the previous operation |
| sub_in | input | 1 | 1 when the previous operation was a subtraction |
| acc_out | output | 8 | Adjusted accumulator |
| sign_out | output | 1 | Bit 7 of the result |
| zero_out | output | 1 | Result equals zero |
| half_out | output | 1 | New half-carry flag |
| parity_out | output | 1 | Result has even parity |
| sub_out | output | 1 | Subtract flag passed through |
| carry_out | output | 1 | New carry flag |
| bit3_copy | output | 1 | Copy of result bit 3 |
| bit5_copy | output | 1 | Copy of result bit 5 |

## Verification
Every output is a function of the present inputs only, so each result is due in the same cycle as its stimulus, with no register in the path. The bench changes the inputs just after a rising clock edge and compares all outputs at the following falling edge, half a period later, so the combinational paths have settled before sampling. The expected values come from a decimal-digit model in the bench that subtracts the correction byte rather than adding constants. Random vectors over all flag combinations are mixed with directed wrap, boundary-nibble and zero-result cases.

// File: rtl/bcd_adjust.sv
module bcd_adjust (
  input  logic [7:0] acc_in,
  input  logic       half_in,
  input  logic       carry_in,
  input  logic       sub_in,
  output logic [7:0] acc_out,
  output logic       sign_out,
  output logic       zero_out,
  output logic       half_out,
  output logic       parity_out,
  output logic       sub_out,
  output logic       carry_out,
  output logic       bit3_copy,
  output logic       bit5_copy
);
  localparam logic [7:0] ADD_LO   = 8'h06;
  localparam logic [7:0] ADD_HI   = 8'h60;
  localparam logic [7:0] ADD_BOTH = 8'h66;
  localparam logic [7:0] SUB_LO   = 8'hFA;
  localparam logic [7:0] SUB_HI   = 8'hA0;
  localparam logic [7:0] SUB_BOTH = 8'h9A;

  logic       fix_lo;
  logic       fix_hi;
  logic [7:0] corr;
  logic [3:0] lo_nib;

  assign lo_nib = acc_in[3:0];
  assign fix_lo = (lo_nib > 4'h9) | half_in;
  assign fix_hi = (acc_in > 8'h99) | carry_in;

  always_comb begin
    unique case ({sub_in, fix_hi, fix_lo})
      3'b001:  corr = ADD_LO;
      3'b010:  corr = ADD_HI;
      3'b011:  corr = ADD_BOTH;
      3'b101:  corr = SUB_LO;
      3'b110:  corr = SUB_HI;
      3'b111:  corr = SUB_BOTH;
      default: corr = 8'h00;
    endcase
  end

  assign acc_out = acc_in + corr;

  always_comb begin
    if (!sub_in)       half_out = (lo_nib >= 4'hA);
    else if (half_in)  half_out = (lo_nib < 4'h6);
    else               half_out = 1'b0;
  end

  assign sign_out   = acc_out[7];
  assign zero_out   = (acc_out == 8'h00);
  assign parity_out = ~^acc_out;
  assign bit3_copy  = acc_out[3];
  assign bit5_copy  = acc_out[5];
  assign sub_out    = sub_in;
  assign carry_out  = carry_in | fix_hi;
endmodule

// File: rtl/bcd_adjust_chk.sv
module bcd_adjust_chk (
  input logic [7:0] acc_in,
  input logic       half_in,
  input logic       carry_in,
  input logic       sub_in,
  input logic [7:0] acc_out,
  input logic       sign_out,
  input logic       zero_out,
  input logic       half_out,
  input logic       parity_out,
  input logic       sub_out,
  input logic       carry_out
);
  always_comb begin
    // R2 / R8: an incoming carry is never cleared
    p_carry_keep_r8: assert (!carry_in || carry_out)
      else $error("carry lost");
    // R2: a byte above 0x99 always reports carry
    p_carry_force_r2: assert (!(acc_in > 8'h99) || carry_out)
      else $error("carry not forced");
    // R4: no repair selected leaves the byte untouched
    p_no_fix_r4: assert (!(!half_in && !carry_in && acc_in[3:0] <= 4'h9 && acc_in <= 8'h99)
                         || (acc_out == acc_in))
      else $error("unrepaired byte changed");
    // R5: subtract without half-carry clears half-carry
    p_half_clear_r5: assert (!(sub_in && !half_in) || !half_out)
      else $error("half-carry not cleared");
    // R6: a zero result has even parity and no sign
    p_zero_flags_r6: assert (!zero_out || (parity_out && !sign_out))
      else $error("zero result flags inconsistent");
    // R8: subtract flag is preserved
    p_sub_pass_r8: assert (sub_out == sub_in)
      else $error("subtract flag altered");
  end
endmodule

bind bcd_adjust bcd_adjust_chk u_chk (
  .acc_in(acc_in), .half_in(half_in), .carry_in(carry_in), .sub_in(sub_in),
  .acc_out(acc_out), .sign_out(sign_out), .zero_out(zero_out),
  .half_out(half_out), .parity_out(parity_out), .sub_out(sub_out),
  .carry_out(carry_out)
);

// File: tb/bcd_adjust_test.sv
module bcd_adjust_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [7:0] acc_in = 8'h00;
  logic half_in = 1'b0, carry_in = 1'b0, sub_in = 1'b0;
  logic [7:0] acc_out;
  logic sign_out, zero_out, half_out, parity_out, sub_out, carry_out, bit3_copy, bit5_copy;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  bcd_adjust uut (
    .acc_in(acc_in), .half_in(half_in), .carry_in(carry_in), .sub_in(sub_in),
    .acc_out(acc_out), .sign_out(sign_out), .zero_out(zero_out),
    .half_out(half_out), .parity_out(parity_out), .sub_out(sub_out),
    .carry_out(carry_out), .bit3_copy(bit3_copy), .bit5_copy(bit5_copy)
  );

  function automatic logic [7:0] model_acc(logic [7:0] a, logic h, logic c, logic n);
    logic [7:0] step;
    step = 8'h00;
    if (a[3:0] > 4'd9 || h) step = step + 8'd6;
    if (a > 8'h99 || c)     step = step + 8'h60;
    return n ? (a - step) : (a + step);
  endfunction

  function automatic logic model_half(logic [7:0] a, logic h, logic n);
    if (n) return h && (a[3:0] < 4'd6);
    return a[3:0] >= 4'd10;
  endfunction

  function automatic logic even_ones(logic [7:0] v);
    int k = 0;
    for (int i = 0; i < 8; i++) if (v[i]) k++;
    return (k % 2) == 0;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h (acc=%0h h=%0b c=%0b n=%0b)",
               tag, act, exp, acc_in, half_in, carry_in, sub_in);
    end
  endtask

  task automatic apply(logic [7:0] a, logic h, logic c, logic n);
    logic [7:0] r;
    @(posedge clk); #0.5;
    acc_in = a; half_in = h; carry_in = c; sub_in = n;
    @(negedge clk);
    r = model_acc(a, h, c, n);
    chk("R3/R4 result", acc_out, r);
    chk("R2 carry", carry_out, c | (a > 8'h99));
    chk("R5 half", half_out, model_half(a, h, n));
    chk("R6 sign", sign_out, r[7]);
    chk("R6 zero", zero_out, r == 8'h00);
    chk("R6 parity", parity_out, even_ones(r));
    chk("R7 bit3", bit3_copy, r[3]);
    chk("R7 bit5", bit5_copy, r[5]);
    chk("R8 sub", sub_out, n);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    seed = 32'd12345;
    void'($urandom(seed));
    @(negedge clk);
    chk("reset R4 idle", acc_out, 8'h00);
    chk("reset R6 zero", zero_out, 1);

    apply(8'h0C, 0, 0, 0); chk("R1 low digit", acc_out, 8'h12);
    apply(8'h12, 1, 0, 0); chk("R1 half_in", acc_out, 8'h18);
    apply(8'hA3, 0, 0, 0); chk("R2 high digit", acc_out, 8'h03);
    chk("R2 forced carry", carry_out, 1);
    apply(8'h45, 1, 1, 0); chk("R3 both add", acc_out, 8'hAB);
    apply(8'h0F, 1, 0, 1); chk("R4 low sub", acc_out, 8'h09);
    apply(8'h87, 0, 1, 1); chk("R4 high sub", acc_out, 8'h27);
    apply(8'hFF, 1, 1, 1); chk("R4 both sub", acc_out, 8'h99);
    apply(8'h99, 0, 0, 1); chk("R4 unchanged", acc_out, 8'h99);
    chk("R8 carry kept 0", carry_out, 0);
    apply(8'h99, 0, 0, 0); chk("R4 unchanged add", acc_out, 8'h99);
    apply(8'h05, 1, 0, 1); chk("R5 sub h=1 low<6", half_out, 1);
    apply(8'h06, 1, 0, 1); chk("R5 sub h=1 low=6", half_out, 0);
    apply(8'h0F, 0, 0, 1); chk("R5 sub h=0", half_out, 0);
    apply(8'h09, 1, 0, 0); chk("R5 add low=9", half_out, 0);
    apply(8'h9A, 0, 0, 0); chk("R9 wrap result", acc_out, 8'h00);
    chk("R9 wrap carry", carry_out, 1);
    chk("R9 wrap zero", zero_out, 1);
    chk("R9 wrap half", half_out, 1);
    apply(8'hFA, 0, 0, 0); chk("R9 wrap high", acc_out, 8'h60);
    apply(8'h00, 0, 1, 1); chk("R9 sub wrap", acc_out, 8'hA0);

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] v;
      v = $urandom;
      apply(v[7:0], v[8], v[9], v[10]);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule